// File: doc/BRIEF.md
# Indirect PHY Parameter Access Port

This block is a register front end that lets software reach a bank of small 8-bit PHY tuning parameters. It does not map them one by one. Software writes a single test-input word that names a parameter slot, carries a data byte and holds a write strobe bit. The block commits the byte into the slot when the strobe bit goes from low to high. The selected slot's value comes back through a test-output word. That value passes through a short pipeline, so a fixed number of test-output reads must be made before the new selection shows up.

The same port also holds two configuration registers whose fields drive the PHY directly. One is a 3-bit port selection in a clock-control register. The other is a reset register with a manual-mode flag and an active-low PHY reset. The bus is a simple 32-bit register interface with separate read and write strobes. Read data is registered and appears the cycle after the read strobe.

Top module: `phy_param_port`

## Requirements
- R1: After reset, every register is zero. `phy_rst_n` is 0, `phy_manual_mode` is 0 and `phy_port_sel` is 0. Reads of the test-output word return 0.
- R2: A write to offset 0x0000 stores bits 11:9 as the port select, which drives `phy_port_sel` from the next cycle. A read of 0x0000 returns the field in bits 11:9 with all other bits zero.
- R3: A write to offset 0x200C stores bit 8 as the manual-mode flag and bit 0 as the active-low PHY reset (1 releases reset). Both drive the PHY outputs from the next cycle. A read returns them in the same positions with all other bits zero.
- R4: The test-input word is at offset 0x2000, with bit 0 the write strobe, bits 5:1 the parameter slot and bits 13:6 the data byte. A read returns those 14 bits with bits 31:14 zero.
- R5: A test-input write whose bit 0 is 1, while the stored bit 0 is 0, writes the data byte into the named slot. All 32 slots, 0 through 31, can be written.
- R6: A test-input write with bit 0 equal to 1 while the stored bit 0 is already 1 commits nothing, even when the data differs.
- R7: A test-input write with bit 0 equal to 0 selects the named slot for reading and changes no slot's contents.
- R8: The test-output word is at offset 0x2004. Each read returns an 8-bit value in bits 7:0 with bits 31:8 zero. Each read advances a two-stage pipeline fed from the selected slot, so the third read after a selection change returns the newly selected slot's value. The first two reads return the earlier pipeline contents.
- R9: Reads of any other offset return zero. Writes to any other offset change no output and no register.
- R10: `bus_rdata` is loaded only on the clock edge that samples `bus_rd_en`, and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| phy_port_sel | output | 3 | Port selection driven to the PHY |
| phy_manual_mode | output | 1 | Manual reset mode flag to the PHY |
| phy_rst_n | output | 1 | Active-low PHY reset, 1 releases |

## Verification
The PHY control outputs change one clock after the write strobe. `bus_rdata` changes one clock after the read strobe, so the bench samples it on the falling edge that follows the capturing rising edge. A test-output value is due on the third test-output read after a test-input write. The scoreboard queues each read's expected word when the read is issued, and it marks the first two reads after a selection change as "don't care", except in the lag check. In the lag check those two reads are predicted exactly from the earlier selection. Control outputs are compared on the falling edge after each write completes.

// File: rtl/phy_param_port.sv
module phy_param_port #(
  parameter int BUS_W   = 32,
  parameter int OFS_W   = 16,
  parameter int PADDR_W = 5,
  parameter int PDATA_W = 8,
  parameter int SEL_W   = 3,
  parameter int OUT_LAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [SEL_W-1:0] phy_port_sel,
  output logic             phy_manual_mode,
  output logic             phy_rst_n
);
  localparam int NPARAM   = 1 << PADDR_W;
  localparam int SEL_LSB  = 9;
  localparam int MAN_BIT  = 8;
  localparam int ADR_LSB  = 1;
  localparam int DAT_LSB  = ADR_LSB + PADDR_W;
  localparam int TIN_W    = DAT_LSB + PDATA_W;
  localparam logic [OFS_W-1:0] OFS_CLK  = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_TIN  = 16'h2000;
  localparam logic [OFS_W-1:0] OFS_TOUT = 16'h2004;
  localparam logic [OFS_W-1:0] OFS_RST  = 16'h200C;

  logic [SEL_W-1:0]   port_sel_q;
  logic               manual_q, rstn_q;
  logic               tin_we_q;
  logic [PADDR_W-1:0] tin_addr_q;
  logic [PDATA_W-1:0] tin_data_q;
  logic [PDATA_W-1:0] param_q [NPARAM];
  logic [PDATA_W-1:0] lag_q [OUT_LAG];
  logic [BUS_W-1:0]   rd_val;
  logic               unused_bits;

  wire hit_clk  = (bus_addr == OFS_CLK);
  wire hit_tin  = (bus_addr == OFS_TIN);
  wire hit_tout = (bus_addr == OFS_TOUT);
  wire hit_rst  = (bus_addr == OFS_RST);

  wire [PADDR_W-1:0] w_addr = bus_wdata[DAT_LSB-1:ADR_LSB];
  wire [PDATA_W-1:0] w_data = bus_wdata[TIN_W-1:DAT_LSB];
  wire commit   = bus_wr_en & hit_tin & bus_wdata[0] & ~tin_we_q;
  wire tout_adv = bus_rd_en & hit_tout;

  assign unused_bits     = ^bus_wdata;
  assign phy_port_sel    = port_sel_q;
  assign phy_manual_mode = manual_q;
  assign phy_rst_n       = rstn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_sel_q <= '0;
    end else if (bus_wr_en && hit_clk) begin
      port_sel_q <= bus_wdata[SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual_q <= 1'b0;
      rstn_q   <= 1'b0;
    end else if (bus_wr_en && hit_rst) begin
      manual_q <= bus_wdata[MAN_BIT];
      rstn_q   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tin_we_q   <= 1'b0;
      tin_addr_q <= '0;
      tin_data_q <= '0;
    end else if (bus_wr_en && hit_tin) begin
      tin_we_q   <= bus_wdata[0];
      tin_addr_q <= w_addr;
      tin_data_q <= w_data;
    end
  end

  for (genvar i = 0; i < NPARAM; i++) begin : g_param
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        param_q[i] <= '0;
      end else if (commit && (w_addr == PADDR_W'(i))) begin
        param_q[i] <= w_data;
      end
    end
  end

  for (genvar s = 0; s < OUT_LAG; s++) begin : g_lag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lag_q[s] <= '0;
      end else if (tout_adv) begin
        if (s == 0) lag_q[s] <= param_q[tin_addr_q];
        else        lag_q[s] <= lag_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_clk) begin
      rd_val[SEL_LSB +: SEL_W] = port_sel_q;
    end else if (hit_rst) begin
      rd_val[MAN_BIT] = manual_q;
      rd_val[0]       = rstn_q;
    end else if (hit_tin) begin
      rd_val[0]                    = tin_we_q;
      rd_val[DAT_LSB-1:ADR_LSB]    = tin_addr_q;
      rd_val[TIN_W-1:DAT_LSB]      = tin_data_q;
    end else if (hit_tout) begin
      rd_val[PDATA_W-1:0] = lag_q[OUT_LAG-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_val;
  end
endmodule

module phy_param_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [2:0]  phy_port_sel,
  input logic        phy_manual_mode,
  input logic        phy_rst_n
);
  wire mapped = (bus_addr == 16'h0000) || (bus_addr == 16'h2000) ||
                (bus_addr == 16'h2004) || (bus_addr == 16'h200C);

  assert_port_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_addr == 16'h0000 |=> phy_port_sel == $past(bus_wdata[11:9]));

  assert_rst_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_addr == 16'h200C |=>
      phy_rst_n == $past(bus_wdata[0]) && phy_manual_mode == $past(bus_wdata[8]));

  assert_tout_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en && bus_addr == 16'h2004 |=> bus_rdata[31:8] == 24'h0);

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en && !mapped |=> bus_rdata == 32'h0);

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && !mapped |=> $stable({phy_port_sel, phy_manual_mode, phy_rst_n}));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind phy_param_port phy_param_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .phy_port_sel(phy_port_sel), .phy_manual_mode(phy_manual_mode),
  .phy_rst_n(phy_rst_n)
);

// File: tb/sim_phy_param_port.sv
`timescale 1ns/1ps
module sim_phy_param_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  phy_port_sel;
  logic        phy_manual_mode;
  logic        phy_rst_n;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { logic [31:0] exp; bit care; string tag; } exp_t;
  exp_t sb[$];
  logic mon_pending = 1'b0;

  always #4 clk = ~clk;

  phy_param_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_port_sel(phy_port_sel), .phy_manual_mode(phy_manual_mode),
    .phy_rst_n(phy_rst_n)
  );

  always @(posedge clk) mon_pending <= bus_rd_en;

  always @(negedge clk) begin
    if (mon_pending && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.care) begin
        vectors++;
        if (bus_rdata !== e.exp) begin
          miscompares++;
          $display("FAIL %s: rdata=%08h expected=%08h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input bit care, input string tag);
    exp_t e;
    @(negedge clk);
    e.exp = exp; e.care = care; e.tag = tag;
    sb.push_back(e);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  function automatic logic [31:0] tin(input logic [4:0] slot, input logic [7:0] d, input bit we);
    return {18'h0, d, slot, we};
  endfunction

  task automatic pwrite(input logic [4:0] slot, input logic [7:0] d);
    wr(16'h2000, tin(slot, d, 1'b0));
    wr(16'h2000, tin(slot, d, 1'b1));
    wr(16'h2000, tin(slot, d, 1'b0));
  endtask

  task automatic pread(input logic [4:0] slot, input logic [7:0] exp, input string tag);
    wr(16'h2000, tin(slot, 8'h5A, 1'b0));
    rd(16'h2004, 32'h0, 1'b0, tag);
    rd(16'h2004, 32'h0, 1'b0, tag);
    rd(16'h2004, {24'h0, exp}, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 port_sel", {29'h0, phy_port_sel}, 32'h0);
    check("R1 manual", {31'h0, phy_manual_mode}, 32'h0);
    check("R1 rst_n", {31'h0, phy_rst_n}, 32'h0);
    rd(16'h2004, 32'h0, 1'b1, "R1 tout");
    rd(16'h200C, 32'h0, 1'b1, "R1 rstreg");

    // R2 clock control
    wr(16'h0000, 32'hFFFF_FFFF);
    check("R2 port_sel all", {29'h0, phy_port_sel}, 32'h7);
    rd(16'h0000, 32'h0000_0E00, 1'b1, "R2 readback");
    wr(16'h0000, 32'h0000_0200);
    check("R2 port_sel one", {29'h0, phy_port_sel}, 32'h1);

    // R3 reset register
    wr(16'h200C, 32'h0000_0100);
    check("R3 manual", {31'h0, phy_manual_mode}, 32'h1);
    check("R3 rst held", {31'h0, phy_rst_n}, 32'h0);
    wr(16'h200C, 32'hFFFF_FFFF);
    check("R3 rst release", {31'h0, phy_rst_n}, 32'h1);
    rd(16'h200C, 32'h0000_0101, 1'b1, "R3 readback");

    // R5 R7 basic write then select
    pwrite(5'd5, 8'hA5);
    pread(5'd5, 8'hA5, "R5 slot5");
    // R7: data with strobe low does not commit (pread used data 5A)
    pread(5'd5, 8'hA5, "R7 no commit");

    // R4 test-input readback with upper garbage
    wr(16'h2000, 32'hFFFF_0F0A);
    rd(16'h2000, 32'h0000_0F0A, 1'b1, "R4 readback");

    // R6 strobe held high commits once
    wr(16'h2000, tin(5'd7, 8'h00, 1'b0));
    wr(16'h2000, tin(5'd7, 8'h11, 1'b1));
    wr(16'h2000, tin(5'd7, 8'h22, 1'b1));
    wr(16'h2000, tin(5'd7, 8'h22, 1'b0));
    pread(5'd7, 8'h11, "R6 held high");

    // R5 boundary slots
    pwrite(5'd31, 8'hFF);
    pwrite(5'd0, 8'h01);
    pread(5'd31, 8'hFF, "R5 slot31");
    pread(5'd0, 8'h01, "R5 slot0");

    // R8 exact lag
    pwrite(5'd3, 8'h33);
    pwrite(5'd4, 8'h44);
    pread(5'd3, 8'h33, "R8 flush");
    wr(16'h2000, tin(5'd4, 8'h00, 1'b0));
    rd(16'h2004, 32'h33, 1'b1, "R8 lag first");
    rd(16'h2004, 32'h33, 1'b1, "R8 lag second");
    rd(16'h2004, 32'h44, 1'b1, "R8 lag third");

    // R9 unmapped offsets
    wr(16'h1000, 32'hFFFF_FFFF);
    wr(16'h2008, 32'h0000_0000);
    check("R9 port_sel kept", {29'h0, phy_port_sel}, 32'h1);
    check("R9 rst kept", {30'h0, phy_manual_mode, phy_rst_n}, 32'h3);
    rd(16'h1000, 32'h0, 1'b1, "R9 read 1000");
    rd(16'h2008, 32'h0, 1'b1, "R9 read 2008");
    rd(16'h0000, 32'h0000_0200, 1'b1, "R9 clk kept");

    // R10 hold
    rd(16'h200C, 32'h0000_0101, 1'b1, "R10 load");
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 32'h0000_0101);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule